// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front-End

This block is the clocked control path of a single-port synchronous SRAM with a small linear burst counter. It also holds a byte-lane memory array. On every rising clock edge it samples three chip selects, a load/advance select, a write enable, per-byte write selects, an active-low clock enable and a sleep request. From these it picks the cycle type for that edge: deselect, read, dummy read, write, write abort, stall or sleep. The bidirectional data bus is split into an input word, an output word and an output-enable flag.

A load edge starts a new cycle at the external address. An advance edge repeats the previous cycle type at the next address in the current four-word block and ignores the chip selects. A read delivers the addressed word on the output in the cycle that follows the decoding edge. Writes take their data on the same edge as the command. The asynchronous output enable only gates the bus flag, and a write cycle never drives the bus.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is high and after it is released, the block is deselected and `dout_oe_o` is 0, whatever the level of `oe_n_i`.
- R2: A load edge (`sleep_i`=0, `cen_n_i`=0, `ld_n_i`=0) with `ce1_n_i`=1, `ce2_i`=0 or `ce3_n_i`=1 makes a deselect cycle with `dout_oe_o`=0. Advance edges that follow stay deselected.
- R3: A load edge with all chip selects active and `we_n_i`=1 is a read. After that edge, `dout_o` holds the stored word at `addr_i`.
- R4: A load edge reloads the burst address from `addr_i`. An advance edge (`ld_n_i`=1) increments only address bits [1:0], wrapping from 3 to 0, and keeps the upper bits. The chip selects are ignored on advance edges, and the previous cycle type carries on.
- R5: A load edge with `we_n_i`=0 and at least one `bw_n_i` bit low is a write. Lane i (`din_i` bits 8i+7..8i) is stored when `bw_n_i[i]`=0.
- R6: A load edge with `we_n_i`=0 and all `bw_n_i` bits high is a write abort. It stores nothing, and its advance beats store nothing whatever `bw_n_i` is.
- R7: On an advance beat of a write, only the lanes whose `bw_n_i` bit is low in that beat are stored. With all bits high, the beat stores nothing.
- R8: An edge with `cen_n_i`=1 and `sleep_i`=0 is a stall. The burst address, the cycle type and `dout_o` stay unchanged.
- R9: An edge with `sleep_i`=1 enters sleep whatever the other inputs are, and `dout_oe_o` is 0 until a later read. An advance edge taken from sleep gives a deselect.
- R10: `dout_oe_o` follows `oe_n_i` combinationally. It is 1 only in a read cycle with `oe_n_i`=0.
- R11: In write and write-abort cycles, `dout_oe_o` is 0 even with `oe_n_i`=0.
- R12: A read with `oe_n_i`=1 (dummy read) still advances the burst and leaves `dout_oe_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | Sleep request, overrides all other controls |
| cen_n_i | input | 1 | Clock enable, active low; high stalls the edge |
| ce1_n_i | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| ce3_n_i | input | 1 | Chip select, active low |
| ld_n_i | input | 1 | Low: load a new cycle; high: advance the burst |
| we_n_i | input | 1 | Write enable, active low |
| bw_n_i | input | BYTES | Per-lane write selects, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | External word address |
| din_i | input | BYTES*LANE_W | Write data |
| dout_o | output | BYTES*LANE_W | Read data |
| dout_oe_o | output | 1 | Bus drive enable for dout_o |

## Verification
Some behaviour is checked by the assertions on every edge. These are bus silence in write, abort and sleep cycles and with the output enable inactive, the deselect produced by a bad chip-select pattern, the load and wrap of the burst address, and the freeze during stalls. Data integrity can only be shown by the bench scenarios run against a reference array. That covers byte-masked merging across burst beats, the fact that aborts and masked beats leave memory untouched, read-back after wrap, dummy reads that move the address without driving, and the output-enable response within a cycle.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL = 3'd0,
    CYC_READ  = 3'd1,
    CYC_WRITE = 3'd2,
    CYC_ABORT = 3'd3,
    CYC_SLEEP = 3'd4
  } cyc_e;
endpackage

// File: rtl/sbs_decode.sv
`timescale 1ns/1ps
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  cyc_e             cur_kind,
  input  logic             sleep_i,
  input  logic             cen_n_i,
  input  logic             ld_n_i,
  input  logic             ce1_n_i,
  input  logic             ce2_i,
  input  logic             ce3_n_i,
  input  logic             we_n_i,
  input  logic [BYTES-1:0] bw_n_i,
  output cyc_e             nxt_kind,
  output logic             load,
  output logic             adv,
  output logic             rd_en,
  output logic [BYTES-1:0] lane_we
);
  logic hold;
  logic sel_ok;

  assign hold   = !sleep_i && cen_n_i;
  assign load   = !sleep_i && !cen_n_i && !ld_n_i;
  assign adv    = !sleep_i && !cen_n_i && ld_n_i;
  assign sel_ok = !ce1_n_i && ce2_i && !ce3_n_i;

  always_comb begin
    if (sleep_i) begin
      nxt_kind = CYC_SLEEP;
    end else if (hold) begin
      nxt_kind = cur_kind;
    end else if (load) begin
      if (!sel_ok)      nxt_kind = CYC_DESEL;
      else if (we_n_i)  nxt_kind = CYC_READ;
      else if (&bw_n_i) nxt_kind = CYC_ABORT;
      else              nxt_kind = CYC_WRITE;
    end else if (cur_kind == CYC_SLEEP) begin
      nxt_kind = CYC_DESEL;
    end else begin
      nxt_kind = cur_kind;
    end
  end

  assign rd_en   = (nxt_kind == CYC_READ) && !hold && !sleep_i;
  assign lane_we = ((nxt_kind == CYC_WRITE) && !hold && !sleep_i) ? ~bw_n_i : '0;
endmodule

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
module sbs_burst_ctr #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt
);
  localparam logic [BURST_W-1:0] STEP = BURST_W'(1);

  logic [ADDR_W-1:0] addr_inc;

  generate
    if (BURST_W >= ADDR_W) begin : g_full
      assign addr_inc = addr_q + ADDR_W'(1);
    end else begin : g_wrap
      assign addr_inc = {addr_q[ADDR_W-1:BURST_W], addr_q[BURST_W-1:0] + STEP};
    end
  endgenerate

  always_comb begin
    if (load)     addr_nxt = addr_i;
    else if (adv) addr_nxt = addr_inc;
    else          addr_nxt = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_nxt;
  end
endmodule

// File: rtl/sbs_lane_ram.sv
`timescale 1ns/1ps
module sbs_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd <= mem[addr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BYTES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep_i,
  input  logic                    cen_n_i,
  input  logic                    ce1_n_i,
  input  logic                    ce2_i,
  input  logic                    ce3_n_i,
  input  logic                    ld_n_i,
  input  logic                    we_n_i,
  input  logic [BYTES-1:0]        bw_n_i,
  input  logic                    oe_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES*LANE_W-1:0] din_i,
  output logic [BYTES*LANE_W-1:0] dout_o,
  output logic                    dout_oe_o
);
  cyc_e              cyc_q;
  cyc_e              cyc_d;
  logic              load;
  logic              adv;
  logic              rd_en;
  logic [BYTES-1:0]  lane_we;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;

  sbs_decode #(.BYTES(BYTES)) u_dec (
    .cur_kind (cyc_q),
    .sleep_i  (sleep_i),
    .cen_n_i  (cen_n_i),
    .ld_n_i   (ld_n_i),
    .ce1_n_i  (ce1_n_i),
    .ce2_i    (ce2_i),
    .ce3_n_i  (ce3_n_i),
    .we_n_i   (we_n_i),
    .bw_n_i   (bw_n_i),
    .nxt_kind (cyc_d),
    .load     (load),
    .adv      (adv),
    .rd_en    (rd_en),
    .lane_we  (lane_we)
  );

  sbs_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .adv      (adv),
    .addr_i   (addr_i),
    .addr_q   (addr_q),
    .addr_nxt (addr_nxt)
  );

  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
      sbs_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
        .clk  (clk),
        .we   (lane_we[g]),
        .re   (rd_en),
        .addr (addr_nxt),
        .wd   (din_i[g*LANE_W +: LANE_W]),
        .rd   (dout_o[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= CYC_DESEL;
    else     cyc_q <= cyc_d;
  end

  assign dout_oe_o = (cyc_q == CYC_READ) && !oe_n_i;
endmodule

// File: rtl/sbs_chk.sv
`timescale 1ns/1ps
module sbs_chk
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_i,
  input logic              cen_n_i,
  input logic              ce1_n_i,
  input logic              ce2_i,
  input logic              ce3_n_i,
  input logic              ld_n_i,
  input logic              oe_n_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_oe_o,
  input cyc_e              cyc_q,
  input logic [ADDR_W-1:0] addr_q
);
  localparam logic [BURST_W-1:0] STEP = BURST_W'(1);

  // R2
  desel_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !cen_n_i && !ld_n_i && (ce1_n_i || !ce2_i || ce3_n_i))
    |=> (cyc_q == CYC_DESEL) && !dout_oe_o);

  // R4
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !cen_n_i && !ld_n_i) |=> addr_q == $past(addr_i));

  // R4
  addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !cen_n_i && ld_n_i)
    |=> (addr_q[BURST_W-1:0] == $past(addr_q[BURST_W-1:0]) + STEP)
        && (addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W])));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cen_n_i && !sleep_i)
    |=> $stable(addr_q) && $stable(dout_o) && $stable(cyc_q));

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> (cyc_q == CYC_SLEEP) && !dout_oe_o);

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> !dout_oe_o);

  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == CYC_WRITE || cyc_q == CYC_ABORT) |-> !dout_oe_o);
endmodule

bind sync_burst_sram sbs_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (BYTES*LANE_W),
  .BURST_W(BURST_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sleep_i   (sleep_i),
  .cen_n_i   (cen_n_i),
  .ce1_n_i   (ce1_n_i),
  .ce2_i     (ce2_i),
  .ce3_n_i   (ce3_n_i),
  .ld_n_i    (ld_n_i),
  .oe_n_i    (oe_n_i),
  .addr_i    (addr_i),
  .dout_o    (dout_o),
  .dout_oe_o (dout_oe_o),
  .cyc_q     (cyc_q),
  .addr_q    (addr_q)
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep_i = 1'b0;
  logic        cen_n_i = 1'b0;
  logic        ce1_n_i = 1'b1;
  logic        ce2_i = 1'b0;
  logic        ce3_n_i = 1'b1;
  logic        ld_n_i = 1'b0;
  logic        we_n_i = 1'b1;
  logic [3:0]  bw_n_i = 4'hF;
  logic        oe_n_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] din_i = '0;
  logic [31:0] dout_o;
  logic        dout_oe_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model: 0 desel, 1 read, 2 write, 3 abort, 4 sleep
  int          m_kind = 0;
  logic [7:0]  m_addr = '0;
  logic [31:0] m_dout = '0;
  logic [31:0] ref_mem [256];

  always #2 clk = ~clk;

  sync_burst_sram u_dut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .cen_n_i(cen_n_i),
    .ce1_n_i(ce1_n_i), .ce2_i(ce2_i), .ce3_n_i(ce3_n_i), .ld_n_i(ld_n_i),
    .we_n_i(we_n_i), .bw_n_i(bw_n_i), .oe_n_i(oe_n_i), .addr_i(addr_i),
    .din_i(din_i), .dout_o(dout_o), .dout_oe_o(dout_oe_o)
  );

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'd3};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_kind = 0; m_addr = '0;
    end else if (sleep_i) begin
      m_kind = 4;
    end else if (!cen_n_i) begin
      if (!ld_n_i) begin
        m_addr = addr_i;
        if (ce1_n_i || !ce2_i || ce3_n_i) m_kind = 0;
        else if (we_n_i)                  m_kind = 1;
        else if (bw_n_i == 4'hF)          m_kind = 3;
        else                              m_kind = 2;
      end else begin
        m_addr = {m_addr[7:2], m_addr[1:0] + 2'd1};
        if (m_kind == 4) m_kind = 0;
      end
      if (m_kind == 2)
        for (int i = 0; i < 4; i++)
          if (!bw_n_i[i]) ref_mem[m_addr][i*8 +: 8] = din_i[i*8 +: 8];
      if (m_kind == 1) m_dout = ref_mem[m_addr];
    end
  endtask

  task automatic compare(input string tag);
    logic drv;
    drv = (m_kind == 1) && !oe_n_i;
    chk(tag, {31'd0, dout_oe_o}, {31'd0, drv});
    if (drv) chk(tag, dout_o, m_dout);
  endtask

  // ce: {ce1_n, ce2, ce3_n}; 3'b010 selects the block
  task automatic beat(input logic ld, input logic we, input logic [3:0] bw,
                      input logic [7:0] a, input logic [31:0] d, input logic [2:0] ce,
                      input logic cen, input logic slp, input logic oe, input string tag);
    @(negedge clk);
    ld_n_i = ld; we_n_i = we; bw_n_i = bw; addr_i = a; din_i = d;
    {ce1_n_i, ce2_i, ce3_n_i} = ce;
    cen_n_i = cen; sleep_i = slp; oe_n_i = oe;
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
  endtask

  task automatic rd_load(input logic [7:0] a, input logic oe, input string tag);
    beat(1'b0, 1'b1, 4'hF, a, 32'h0, 3'b010, 1'b0, 1'b0, oe, tag);
  endtask

  task automatic advance(input logic [3:0] bw, input logic [31:0] d, input logic oe, input string tag);
    beat(1'b1, 1'b1, bw, 8'h00, d, 3'b101, 1'b0, 1'b0, oe, tag);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset with output enable active
    for (int i = 0; i < 3; i++)
      beat(1'b0, 1'b1, 4'hF, 8'h10, 32'h0, 3'b010, 1'b0, 1'b0, 1'b0, "R1");
    @(negedge clk); rst = 1'b0;
    ld_n_i = 1'b0; {ce1_n_i, ce2_i, ce3_n_i} = 3'b101;
    @(posedge clk); model_step(); #1; compare("R1");

    // R5 / R7: fill memory with full-mask bursts
    for (int b = 0; b < 256; b += 4) begin
      beat(1'b0, 1'b0, 4'h0, 8'(b), pat(8'(b)), 3'b010, 1'b0, 1'b0, 1'b0, "R5");
      for (int k = 1; k < 4; k++)
        advance(4'h0, pat(8'(b + k)), 1'b0, "R7");
    end

    // R3 / R4: read burst wrapping inside the block (6,7,4,5)
    rd_load(8'h06, 1'b0, "R3");
    for (int k = 0; k < 4; k++) advance(4'hF, 32'h0, 1'b0, "R4");

    // R2: each bad chip-select pattern, then advance
    beat(1'b0, 1'b1, 4'hF, 8'h20, 32'h0, 3'b110, 1'b0, 1'b0, 1'b0, "R2");
    beat(1'b0, 1'b1, 4'hF, 8'h21, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0, "R2");
    beat(1'b0, 1'b1, 4'hF, 8'h22, 32'h0, 3'b011, 1'b0, 1'b0, 1'b0, "R2");
    advance(4'hF, 32'h0, 1'b0, "R2");
    advance(4'hF, 32'h0, 1'b0, "R2");

    // R5 / R7: masked write burst, then read back
    beat(1'b0, 1'b0, 4'b1010, 8'h40, 32'h11223344, 3'b010, 1'b0, 1'b0, 1'b0, "R5");
    advance(4'b0111, 32'hAABBCCDD, 1'b0, "R7");
    advance(4'b1111, 32'hDEADBEEF, 1'b0, "R7");
    advance(4'b1100, 32'h55667788, 1'b0, "R7");
    rd_load(8'h40, 1'b0, "R5");
    for (int k = 0; k < 3; k++) advance(4'hF, 32'h0, 1'b0, "R7");

    // R6: abort load and abort beats with selects active
    beat(1'b0, 1'b0, 4'hF, 8'h50, 32'hFFFFFFFF, 3'b010, 1'b0, 1'b0, 1'b0, "R6");
    advance(4'h0, 32'hFFFFFFFF, 1'b0, "R6");
    advance(4'h0, 32'hFFFFFFFF, 1'b0, "R6");
    rd_load(8'h50, 1'b0, "R6");
    advance(4'hF, 32'h0, 1'b0, "R6");
    advance(4'hF, 32'h0, 1'b0, "R6");

    // R8: stall in the middle of a read burst, inputs busy
    rd_load(8'h61, 1'b0, "R8");
    beat(1'b0, 1'b0, 4'h0, 8'h99, 32'h12345678, 3'b010, 1'b1, 1'b0, 1'b0, "R8");
    beat(1'b1, 1'b1, 4'hF, 8'h00, 32'h0, 3'b010, 1'b1, 1'b0, 1'b0, "R8");
    advance(4'hF, 32'h0, 1'b0, "R8");
    rd_load(8'h99, 1'b0, "R8");

    // R9: sleep with a write pending on the inputs, then advance
    beat(1'b0, 1'b0, 4'h0, 8'h70, 32'hCAFEF00D, 3'b010, 1'b0, 1'b1, 1'b0, "R9");
    beat(1'b0, 1'b1, 4'hF, 8'h70, 32'h0, 3'b010, 1'b1, 1'b1, 1'b0, "R9");
    advance(4'hF, 32'h0, 1'b0, "R9");
    rd_load(8'h70, 1'b0, "R9");

    // R12: dummy read then visible continuation
    rd_load(8'h83, 1'b1, "R12");
    advance(4'hF, 32'h0, 1'b1, "R12");
    advance(4'hF, 32'h0, 1'b0, "R12");

    // R11: write and abort with output enable active
    beat(1'b0, 1'b0, 4'b1110, 8'h90, 32'h000000EE, 3'b010, 1'b0, 1'b0, 1'b0, "R11");
    advance(4'h0, 32'h01020304, 1'b0, "R11");
    beat(1'b0, 1'b0, 4'hF, 8'h94, 32'h0, 3'b010, 1'b0, 1'b0, 1'b0, "R11");
    rd_load(8'h90, 1'b0, "R11");
    advance(4'hF, 32'h0, 1'b0, "R11");

    // R10: output enable toggled inside one read cycle
    rd_load(8'hA2, 1'b0, "R10");
    oe_n_i = 1'b1; #0.5; compare("R10");
    oe_n_i = 1'b0; #0.3; compare("R10");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule